// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a physical frame number by walking a two-level page table held in memory. The client supplies the page number and the physical base of the top-level table and pulses `walk_start`. The walker then issues two reads, one per level, through a read port that carries one request at a time. The walk ends with either a translation (frame number plus read, write and dirty bits) or a fault that names the level where it stopped. Only one walk is in progress at a time. A start pulse that arrives while a walk is running has no effect.

A virtual page number `vpn[19:0]` splits into a top-level index `vpn[19:10]` (virtual address bits 31:22) and a second-level index `vpn[9:0]` (virtual address bits 21:12). The 12-bit page offset never reaches the walker, because pages are 4 KB. Each table entry is 32 bits wide, laid out as follows:

| Bits | Meaning |
|------|---------|
| 0 | valid |
| 1 | resident |
| 2 | readable |
| 3 | writable |
| 4 | dirty |
| 11:5 | ignored |
| 31:12 | frame number |

**States.** The controller has seven states: `ST_IDLE`, `ST_L1_REQ`, `ST_L1_WAIT`, `ST_L2_REQ`, `ST_L2_WAIT`, `ST_DONE` and `ST_FAULT`.

**Transitions.**
- `ST_IDLE` moves to `ST_L1_REQ` on `walk_start`.
- Each `*_REQ` state holds its request until `mem_gnt`, then moves to the matching `*_WAIT` state.
- `ST_L1_WAIT`, on `mem_rvalid`, goes to `ST_FAULT` if the entry is invalid, and to `ST_L2_REQ` otherwise.
- `ST_L2_WAIT`, on `mem_rvalid`, goes to `ST_FAULT` if the entry is invalid or not resident, and to `ST_DONE` otherwise.
- `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset, `busy`, `mem_req` and `rsp_valid` are all 0.
- R2: The first read goes to `root_base + 4*vpn[19:10]`. While `mem_req` is 1 and `mem_gnt` is 0, `mem_req` stays 1 and `mem_addr` stays unchanged.
- R3: The second read goes to `{L1_entry[31:12], 12'h000} + 4*vpn[9:0]`. Bits 11:1 of the top-level entry do not affect this address.
- R4: If the top-level entry has bit 0 clear, the walk ends with `rsp_fault`=1 and `rsp_fault_lvl`=0, and no second read is issued.
- R5: If the second-level entry has bit 0 clear, the walk ends with `rsp_fault`=1 and `rsp_fault_lvl`=1.
- R6: If the second-level entry has bit 0 set but bit 1 clear (not resident), the walk ends with `rsp_fault`=1 and `rsp_fault_lvl`=1.
- R7: On success, `rsp_fault`=0, `rsp_ppn` equals entry bits 31:12, and `rsp_r`, `rsp_w` and `rsp_d` equal entry bits 2, 3 and 4 of the second-level entry.
- R8: `rsp_valid` is 1 for exactly one cycle per walk. In the following cycle `busy` is 0.
- R9: A `walk_start` pulse while `busy` is 1 is ignored. It causes no extra read, no extra response and no change to the running walk.
- R10: At most one read is outstanding. `mem_req` is 0 from a grant until the matching `mem_rvalid`.
- R11: `walk_vpn` and `root_base` are sampled only in the start cycle. Later changes to them do not affect the running walk.
- R12: On a fault response, `rsp_ppn`, `rsp_r`, `rsp_w` and `rsp_d` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Starts a walk when the walker is idle |
| walk_vpn | input | 20 | Virtual page number to translate |
| root_base | input | 32 | Physical base address of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 32 | Read address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table entry) |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | The walk ended in a fault |
| rsp_fault_lvl | output | 1 | Fault level: 0 = top level, 1 = second level |
| rsp_ppn | output | 20 | Translated frame number |
| rsp_r | output | 1 | Readable permission |
| rsp_w | output | 1 | Writable permission |
| rsp_d | output | 1 | Dirty bit |

## Verification
Several properties are checked on every cycle:
- a pending request holds its address until it is granted;
- no request is issued while a read is outstanding;
- the result strobe is a single cycle followed by idle;
- a start pulse during a walk keeps the walker busy;
- the number of grants per walk matches the outcome: one read for a top-level fault, two otherwise.

Other behaviour can only be shown by the bench's scenarios against a memory model. These include the exact read addresses, the decoding of frame and permission bits, the distinction between invalid and non-resident entries, the zeroed outputs on a fault, and the fact that changed inputs after the start pulse are ignored. These scenarios run with varied grant and response delays and include the extreme index values 0 and 1023.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned OFF_W       = 12;
    localparam int unsigned IDX_W       = 10;
    localparam int unsigned LEVELS      = 2;
    localparam int unsigned PTE_BYTES   = 4;

    localparam int unsigned VPN_W       = IDX_W * LEVELS;
    localparam int unsigned FRAME_W     = ADDR_W - OFF_W;
    localparam int unsigned PTE_W       = PTE_BYTES * 8;
    localparam int unsigned ENTRY_SHIFT = $clog2(PTE_BYTES);
    localparam int unsigned FLAG_W      = 5;
    localparam int unsigned SPARE_W     = PTE_W - FRAME_W - FLAG_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SPARE_W-1:0] spare;
        logic               dirty;
        logic               writable;
        logic               readable;
        logic               resident;
        logic               valid;
    } pte_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned AW    = 32,
    parameter int unsigned IW    = 10,
    parameter int unsigned SHIFT = 2
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int unsigned PAD_W = AW - IW - SHIFT;

    logic [AW-1:0] offset;

    assign offset = {{PAD_W{1'b0}}, idx, {SHIFT{1'b0}}};
    assign addr   = base + offset;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]   raw,
    output logic [FRAME_W-1:0] frame,
    output logic               perm_r,
    output logic               perm_w,
    output logic               dirty,
    output logic               table_ok,
    output logic               leaf_ok,
    output logic [ADDR_W-1:0]  next_base
);
    pte_t ent;
    logic unused_spare;

    assign ent          = pte_t'(raw);
    assign unused_spare = ^ent.spare;

    assign frame     = ent.frame;
    assign perm_r    = ent.readable;
    assign perm_w    = ent.writable;
    assign dirty     = ent.dirty;
    assign table_ok  = ent.valid;
    assign leaf_ok   = ent.valid & ent.resident;
    assign next_base = {ent.frame, {OFF_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_start,
    input  logic [VPN_W-1:0]   walk_vpn,
    input  logic [ADDR_W-1:0]  root_base,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [PTE_W-1:0]   mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic               rsp_fault_lvl,
    output logic [FRAME_W-1:0] rsp_ppn,
    output logic               rsp_r,
    output logic               rsp_w,
    output logic               rsp_d
);

    walk_state_e state_q, state_d;

    logic [VPN_W-1:0]   vpn_q;
    logic [ADDR_W-1:0]  root_q;
    logic [ADDR_W-1:0]  next_base_q;
    logic [FRAME_W-1:0] res_ppn_q;
    logic               res_r_q;
    logic               res_w_q;
    logic               res_d_q;
    logic               fault_lvl_q;

    // Per-level table base, index and computed entry address
    logic [ADDR_W-1:0] lvl_base [LEVELS];
    logic [IDX_W-1:0]  lvl_idx  [LEVELS];
    logic [ADDR_W-1:0] lvl_addr [LEVELS];

    assign lvl_base[0] = root_q;
    assign lvl_base[1] = next_base_q;

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        assign lvl_idx[g] = vpn_q[VPN_W-1-g*IDX_W -: IDX_W];

        ptw_addr_gen #(
            .AW    (ADDR_W),
            .IW    (IDX_W),
            .SHIFT (ENTRY_SHIFT)
        ) u_addr (
            .base (lvl_base[g]),
            .idx  (lvl_idx[g]),
            .addr (lvl_addr[g])
        );
    end

    // Decode of the entry arriving on the read port
    logic [FRAME_W-1:0] dec_frame;
    logic               dec_r;
    logic               dec_w;
    logic               dec_d;
    logic               dec_table_ok;
    logic               dec_leaf_ok;
    logic [ADDR_W-1:0]  dec_next_base;

    ptw_pte_decode u_dec (
        .raw       (mem_rdata),
        .frame     (dec_frame),
        .perm_r    (dec_r),
        .perm_w    (dec_w),
        .dirty     (dec_d),
        .table_ok  (dec_table_ok),
        .leaf_ok   (dec_leaf_ok),
        .next_base (dec_next_base)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (walk_start) state_d = ST_L1_REQ;
            end
            ST_L1_REQ: begin
                if (mem_gnt) state_d = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rvalid) state_d = dec_table_ok ? ST_L2_REQ : ST_FAULT;
            end
            ST_L2_REQ: begin
                if (mem_gnt) state_d = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rvalid) state_d = dec_leaf_ok ? ST_DONE : ST_FAULT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Walk context and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q       <= '0;
            root_q      <= '0;
            next_base_q <= '0;
            res_ppn_q   <= '0;
            res_r_q     <= 1'b0;
            res_w_q     <= 1'b0;
            res_d_q     <= 1'b0;
            fault_lvl_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && walk_start) begin
                vpn_q  <= walk_vpn;
                root_q <= root_base;
            end
            if (state_q == ST_L1_WAIT && mem_rvalid) begin
                next_base_q <= dec_next_base;
                fault_lvl_q <= 1'b0;
            end
            if (state_q == ST_L2_WAIT && mem_rvalid) begin
                res_ppn_q   <= dec_frame;
                res_r_q     <= dec_r;
                res_w_q     <= dec_w;
                res_d_q     <= dec_d;
                fault_lvl_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy          = 1'b1;
        mem_req       = 1'b0;
        mem_addr      = '0;
        rsp_valid     = 1'b0;
        rsp_fault     = 1'b0;
        rsp_fault_lvl = 1'b0;
        rsp_ppn       = '0;
        rsp_r         = 1'b0;
        rsp_w         = 1'b0;
        rsp_d         = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_L1_REQ: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[0];
            end
            ST_L2_REQ: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[1];
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_ppn   = res_ppn_q;
                rsp_r     = res_r_q;
                rsp_w     = res_w_q;
                rsp_d     = res_d_q;
            end
            ST_FAULT: begin
                rsp_valid     = 1'b1;
                rsp_fault     = 1'b1;
                rsp_fault_lvl = fault_lvl_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              walk_start,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic              rsp_fault_lvl
);
    logic       pending;
    logic [1:0] n_grants;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            n_grants <= '0;
        end else begin
            if (mem_req && mem_gnt)   pending <= 1'b1;
            else if (mem_rvalid)      pending <= 1'b0;

            if (walk_start && !busy)  n_grants <= '0;
            else if (mem_req && mem_gnt && n_grants != 2'd3)
                                      n_grants <= n_grants + 2'd1;
        end
    end

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !mem_req);

    a_r8_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && walk_start && !rsp_valid) |=> busy);

    a_r4_l1_fault_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_fault_lvl) |-> (n_grants == 2'd1));

    a_r7_full_walk_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (!rsp_fault || rsp_fault_lvl)) |-> (n_grants == 2'd2));

    a_r8_fault_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_start    (walk_start),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_gnt       (mem_gnt),
    .mem_rvalid    (mem_rvalid),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    import ptw_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               walk_start;
    logic [VPN_W-1:0]   walk_vpn;
    logic [ADDR_W-1:0]  root_base;
    logic               busy;
    logic               mem_req;
    logic [ADDR_W-1:0]  mem_addr;
    logic               mem_gnt;
    logic               mem_rvalid;
    logic [PTE_W-1:0]   mem_rdata;
    logic               rsp_valid;
    logic               rsp_fault;
    logic               rsp_fault_lvl;
    logic [FRAME_W-1:0] rsp_ppn;
    logic               rsp_r;
    logic               rsp_w;
    logic               rsp_d;

    pt_walker dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .walk_start    (walk_start),
        .walk_vpn      (walk_vpn),
        .root_base     (root_base),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_fault_lvl (rsp_fault_lvl),
        .rsp_ppn       (rsp_ppn),
        .rsp_r         (rsp_r),
        .rsp_w         (rsp_w),
        .rsp_d         (rsp_d)
    );

    int checks    = 0;
    int failures  = 0;
    int gnt_delay = 0;
    int rsp_delay = 0;
    int rsp_seen  = 0;
    bit finished  = 1'b0;

    logic [31:0] pmem [logic [31:0]];

    // Scoreboard queues
    logic [31:0] exp_addr_q [$];
    string       exp_atag_q [$];
    bit          exp_fault_q [$];
    bit          exp_lvl_q [$];
    logic [19:0] exp_ppn_q [$];
    logic [2:0]  exp_perm_q [$];
    string       exp_tag_q [$];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 32'h0;
    endfunction

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Memory responder: grants after gnt_delay, answers after rsp_delay
    logic [31:0] req_a;
    logic [31:0] first_a;
    initial begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                first_a = mem_addr;
                repeat (gnt_delay) @(negedge clk);
                chk_eq("R2 address held until grant", mem_addr, first_a);
                req_a   = mem_addr;
                mem_gnt = 1'b1;
                if (exp_addr_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R4 unexpected read actual=0x%08h expected=none", req_a);
                end else begin
                    chk_eq(exp_atag_q.pop_front(), req_a, exp_addr_q.pop_front());
                end
                @(negedge clk);
                mem_gnt = 1'b0;
                chk_eq("R10 no request while read outstanding", {31'b0, mem_req}, 32'h0);
                repeat (rsp_delay) @(negedge clk);
                mem_rdata  = mem_rd(req_a);
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
            end
        end
    end

    // Monitor: pops expected results and compares
    bit prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp) begin
                chk_eq("R8 strobe lasts one cycle", {31'b0, rsp_valid}, 32'h0);
                chk_eq("R8 idle after result", {31'b0, busy}, 32'h0);
            end
            if (rsp_valid) begin
                if (exp_fault_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R9 unexpected response actual=1 expected=0");
                end else begin
                    string t;
                    t = exp_tag_q.pop_front();
                    chk_eq({t, " fault"}, {31'b0, rsp_fault}, {31'b0, exp_fault_q.pop_front()});
                    chk_eq({t, " fault level"}, {31'b0, rsp_fault_lvl}, {31'b0, exp_lvl_q.pop_front()});
                    chk_eq({t, " ppn"}, {12'b0, rsp_ppn}, {12'b0, exp_ppn_q.pop_front()});
                    chk_eq({t, " r/w/d"}, {29'b0, rsp_r, rsp_w, rsp_d}, {29'b0, exp_perm_q.pop_front()});
                    chk_eq({t, " R4 all reads done"}, exp_addr_q.size(), 32'h0);
                    rsp_seen++;
                end
            end
            prev_rsp = rsp_valid;
        end else begin
            prev_rsp = 1'b0;
        end
    end

    // Driver: computes expected reads and result, then starts the walk
    task automatic run_walk(input logic [19:0] vpn, input logic [31:0] root,
                            input int gd, input int rd, input bit intrude, input string tag);
        logic [31:0] a1;
        logic [31:0] e1;
        logic [31:0] a2;
        logic [31:0] e2;
        int          target;
        a1 = root + {20'b0, vpn[19:10], 2'b00};
        e1 = mem_rd(a1);
        exp_addr_q.push_back(a1);
        exp_atag_q.push_back({tag, " R2 first-level address"});
        if (!e1[0]) begin
            exp_fault_q.push_back(1'b1); exp_lvl_q.push_back(1'b0);
            exp_ppn_q.push_back(20'h0);  exp_perm_q.push_back(3'b000);
            exp_tag_q.push_back({tag, " R4 R12"});
        end else begin
            a2 = {e1[31:12], 12'h000} + {20'b0, vpn[9:0], 2'b00};
            e2 = mem_rd(a2);
            exp_addr_q.push_back(a2);
            exp_atag_q.push_back({tag, " R3 second-level address"});
            if (!e2[0]) begin
                exp_fault_q.push_back(1'b1); exp_lvl_q.push_back(1'b1);
                exp_ppn_q.push_back(20'h0);  exp_perm_q.push_back(3'b000);
                exp_tag_q.push_back({tag, " R5 R12"});
            end else if (!e2[1]) begin
                exp_fault_q.push_back(1'b1); exp_lvl_q.push_back(1'b1);
                exp_ppn_q.push_back(20'h0);  exp_perm_q.push_back(3'b000);
                exp_tag_q.push_back({tag, " R6 R12"});
            end else begin
                exp_fault_q.push_back(1'b0); exp_lvl_q.push_back(1'b0);
                exp_ppn_q.push_back(e2[31:12]);
                exp_perm_q.push_back({e2[2], e2[3], e2[4]});
                exp_tag_q.push_back({tag, " R7"});
            end
        end
        gnt_delay = gd;
        rsp_delay = rd;
        target    = rsp_seen + 1;
        while (busy) @(negedge clk);
        walk_vpn   = vpn;
        root_base  = root;
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        // R11: inputs change after the start cycle
        walk_vpn   = ~vpn;
        root_base  = ~root;
        if (intrude) begin
            @(negedge clk);
            walk_vpn   = vpn ^ 20'h00C00;
            walk_start = 1'b1;
            @(negedge clk);
            walk_start = 1'b0;
        end
        while (rsp_seen < target) @(negedge clk);
        repeat (4) @(negedge clk);
        chk_eq({tag, " R9 one response per walk"}, rsp_seen, target);
        chk_eq({tag, " R9 idle after walk"}, {31'b0, busy}, 32'h0);
    endtask

    initial begin
        rst_n      = 1'b0;
        walk_start = 1'b0;
        walk_vpn   = '0;
        root_base  = '0;

        pmem[32'h0001_0004] = 32'h0002_0001;
        pmem[32'h0002_000C] = 32'hABCD_E017;
        pmem[32'h0002_0014] = 32'h1234_501E;
        pmem[32'h0002_0018] = 32'h5555_500D;
        pmem[32'h0030_0FFC] = 32'h0040_0001;
        pmem[32'h0040_0FFC] = 32'hFFFF_F00F;
        pmem[32'h0001_0000] = 32'h0003_0FF1;
        pmem[32'h0003_0000] = 32'h0000_1013;

        repeat (3) @(negedge clk);
        chk_eq("R1 busy in reset", {31'b0, busy}, 32'h0);
        chk_eq("R1 mem_req in reset", {31'b0, mem_req}, 32'h0);
        chk_eq("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 busy after reset", {31'b0, busy}, 32'h0);
        chk_eq("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);

        run_walk(20'h00403, 32'h0001_0000, 0, 0, 1'b0, "S1 plain hit");
        run_walk(20'h00803, 32'h0001_0000, 1, 2, 1'b0, "S2 top-level invalid");
        run_walk(20'h00405, 32'h0001_0000, 0, 1, 1'b0, "S3 leaf invalid");
        run_walk(20'h00406, 32'h0001_0000, 2, 0, 1'b0, "S4 leaf not resident");
        run_walk(20'hFFFFF, 32'h0030_0000, 0, 0, 1'b0, "S5 max indices");
        run_walk(20'h00000, 32'h0001_0000, 3, 3, 1'b0, "S6 zero indices R3 low bits ignored");
        run_walk(20'h00403, 32'h0001_0000, 1, 1, 1'b1, "S7 start while busy R11");
        run_walk(20'h00803, 32'h0001_0000, 0, 0, 1'b0, "S8 fast top-level fault");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule